// File: doc/BRIEF.md
# I2C Target Status and Interrupt Unit

This block holds the status bits and the interrupt request of an I2C target (slave) port. It samples the SCL and SDA lines through a synchronizer and finds start, repeated start and stop conditions. A separate byte engine sends it one-cycle strobes. These strobes report an own-address match together with its read/write bit, a byte loaded into the receive data register, and a byte sent from the transmit data register. The CPU side sends strobes for a receive-data read, a transmit-data write, a write-one-to-clear of the stop-detect flag, and a load of the interrupt enables.

The block presents a 16-bit access-status word, a stop-detect flag and the three enable bits. It drives a single level interrupt line. Each flag has its own set and clear rule. If a set and a clear for the same flag land in one cycle, the set wins.

Top module: `i2c_target_status`

## Requirements
- R1: `status_word` bit 4 is receive-ready, bit 3 is transmit-empty, bit 2 is bus-busy, bit 1 is selected, and bit 0 is direction (1 means the target drives data out). Bits 15..5 always read 0.
- R2: After a synchronous active-low reset, every status bit is 0, including transmit-empty. The stop-detect flag, the enables and `irq` are also 0.
- R3: Receive-ready becomes 1 on the edge that samples `rx_byte_loaded`, and becomes 0 on the edge that samples `rxdata_rd`.
- R4: Transmit-empty becomes 1 on the edge that samples `tx_byte_sent`, and becomes 0 on the edge that samples `txdata_wr`.
- R5: Bus-busy is set by a start condition, or by SCL or SDA being seen low, whether or not the target is selected. It is cleared only by a stop condition.
- R6: Selected becomes 1 on the edge that samples `addr_hit`. It becomes 0 on a stop or a (repeated) start condition.
- R7: Direction loads `addr_rw` with `addr_hit`, returns to 0 when selected clears, and is never 1 while selected is 0.
- R8: The stop-detect flag is set by a stop or a (repeated) start condition seen while selected is 1. The same conditions leave it unchanged while selected is 0.
- R9: A `stopflag_wr` with `stopflag_wdata` = 1 clears the stop-detect flag. With `stopflag_wdata` = 0 it has no effect.
- R10: When a hardware set and a software clear of the same flag fall in one cycle, the flag ends up 1.
- R11: `irq` is 1 exactly while some flag is 1 and its enable is 1. Enable bit 0 gates receive-ready, bit 1 gates transmit-empty, bit 2 gates stop-detect. The enables load from `irq_en_wdata` on `irq_en_wr`.
- R12: Each line passes through two synchronizer flops. A start is SDA going 1 to 0 and a stop is SDA going 0 to 1, with SCL high in both the previous and the current synchronized sample. SDA changes while SCL is low are data, not conditions. A line change shows in the flags after the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line |
| sda_in | input | 1 | Raw SDA line |
| addr_hit | input | 1 | Own address received (strobe) |
| addr_rw | input | 1 | Read/write bit sent with the address, 1 = target transmits |
| rx_byte_loaded | input | 1 | Byte placed in receive data register (strobe) |
| tx_byte_sent | input | 1 | Transmit data byte has gone out (strobe) |
| rxdata_rd | input | 1 | CPU read of the receive data register |
| txdata_wr | input | 1 | CPU write of the transmit data register |
| stopflag_wr | input | 1 | CPU write to the stop-detect flag |
| stopflag_wdata | input | 1 | Data of that write, 1 clears |
| irq_en_wr | input | 1 | CPU write of the interrupt enables |
| irq_en_wdata | input | 3 | New enables {stop, tx, rx} |
| status_word | output | 16 | Access-status word |
| stop_flag | output | 1 | Stop-detect flag |
| irq_en | output | 3 | Current enables {stop, tx, rx} |
| irq | output | 1 | Level interrupt request |

## Verification
The embedded properties assume every engine and CPU input is a one-cycle strobe sampled on the clock. They assume nothing about how the two lines move: any change can arrive on any cycle. Conditions count only after synchronization. The stimulus follows the same rules. It toggles at most one line per cycle, as a real bus does. It fires strobes on random cycles so that set and clear of the same flag often coincide, and it adds directed address, repeated-start and stop sequences.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C target status unit.
// Assumes the status flags are packed MSB first into the low bits of the word.
package i2c_tgt_pkg;
    localparam int IRQ_SRCS = 3;
    localparam int SRC_RX   = 0;
    localparam int SRC_TX   = 1;
    localparam int SRC_STOP = 2;

    // Packed flag order gives rx_ready bit 4 down to dir_out bit 0.
    typedef struct packed {
        logic rx_ready;
        logic tx_empty;
        logic busy;
        logic selected;
        logic dir_out;
    } acc_stat_t;
endpackage

// File: rtl/tgt_line_monitor.sv
// Synchronizes SCL/SDA and reports start, stop and line-low events.
// Assumes raw lines are asynchronous. Pipes reset to 1 (idle bus), so reset
// itself does not raise a false event.
module tgt_line_monitor #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_cond,
    output logic stop_cond,
    output logic line_low
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] scl_pipe;
    logic [LAST:0] sda_pipe;
    logic          scl_prev;
    logic          sda_prev;
    logic          scl_now;
    logic          sda_now;
    logic          scl_held_high;

    // Synchronizer chain plus one history stage for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_in};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_in};
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    // Classify SDA edges under a steady-high SCL.
    always_comb begin
        scl_now       = scl_pipe[LAST];
        sda_now       = sda_pipe[LAST];
        scl_held_high = scl_now & scl_prev;
        start_cond    = scl_held_high & sda_prev & ~sda_now;
        stop_cond     = scl_held_high & ~sda_prev & sda_now;
        line_low      = ~scl_now | ~sda_now;
    end
endmodule

// File: rtl/tgt_status_flags.sv
// Holds the access-status flags, the stop-detect flag and the interrupt enables.
// Assumes all strobes are single-cycle and synchronous. A hardware set outranks
// a software clear in the same cycle.
module tgt_status_flags
    import i2c_tgt_pkg::*;
#(
    parameter int NSRC = IRQ_SRCS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_cond,
    input  logic            stop_cond,
    input  logic            line_low,
    input  logic            addr_hit,
    input  logic            addr_rw,
    input  logic            rx_byte_loaded,
    input  logic            tx_byte_sent,
    input  logic            rxdata_rd,
    input  logic            txdata_wr,
    input  logic            stopflag_wr,
    input  logic            stopflag_wdata,
    input  logic            irq_en_wr,
    input  logic [NSRC-1:0] irq_en_wdata,
    output acc_stat_t       stat,
    output logic            stop_flag,
    output logic [NSRC-1:0] irq_en
);
    logic any_cond;
    logic stop_clear;

    // Event decode shared by several flags.
    always_comb begin
        any_cond   = start_cond | stop_cond;
        stop_clear = stopflag_wr & stopflag_wdata;
    end

    // Flag registers; each set term is tested first so it wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat      <= '0;
            stop_flag <= 1'b0;
            irq_en    <= '0;
        end else begin
            if (rx_byte_loaded)      stat.rx_ready <= 1'b1;
            else if (rxdata_rd)      stat.rx_ready <= 1'b0;

            if (tx_byte_sent)        stat.tx_empty <= 1'b1;
            else if (txdata_wr)      stat.tx_empty <= 1'b0;

            if (start_cond || line_low) stat.busy <= 1'b1;
            else if (stop_cond)         stat.busy <= 1'b0;

            if (addr_hit) begin
                stat.selected <= 1'b1;
                stat.dir_out  <= addr_rw;
            end else if (any_cond) begin
                stat.selected <= 1'b0;
                stat.dir_out  <= 1'b0;
            end

            if (any_cond && stat.selected) stop_flag <= 1'b1;
            else if (stop_clear)           stop_flag <= 1'b0;

            if (irq_en_wr) irq_en <= irq_en_wdata;
        end
    end

    // R3
    rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_byte_loaded |=> stat.rx_ready);

    // R4
    tx_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txdata_wr && !tx_byte_sent) |=> !stat.tx_empty);

    // R5
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cond && !start_cond && !line_low) |=> !stat.busy);

    // R7
    dir_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stat.selected |-> !stat.dir_out);

    // R9
    stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_flag && stopflag_wr && !stopflag_wdata) |=> stop_flag);

    // R8
    stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_flag && !stat.selected) |=> !stop_flag);
endmodule

// File: rtl/tgt_irq_merge.sv
// Gates each interrupt source with its enable and ORs the results.
// Assumes sources are registered flags, so the output is a clean level.
module tgt_irq_merge #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] src,
    input  logic [NSRC-1:0] en,
    output logic            irq
);
    logic [NSRC-1:0] gated;

    // One AND gate per source.
    for (genvar g = 0; g < NSRC; g++) begin : g_gate
        assign gated[g] = src[g] & en[g];
    end

    assign irq = |gated;
endmodule

// File: rtl/i2c_target_status.sv
// Top of the I2C target status unit: line monitor, flag bank, interrupt merge.
// Assumes strobes come from a byte engine and a CPU bus on the same clock.
module i2c_target_status
    import i2c_tgt_pkg::*;
#(
    parameter int STAT_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                addr_hit,
    input  logic                addr_rw,
    input  logic                rx_byte_loaded,
    input  logic                tx_byte_sent,
    input  logic                rxdata_rd,
    input  logic                txdata_wr,
    input  logic                stopflag_wr,
    input  logic                stopflag_wdata,
    input  logic                irq_en_wr,
    input  logic [IRQ_SRCS-1:0] irq_en_wdata,
    output logic [STAT_W-1:0]   status_word,
    output logic                stop_flag,
    output logic [IRQ_SRCS-1:0] irq_en,
    output logic                irq
);
    localparam int FLAG_W = $bits(acc_stat_t);
    localparam int PAD_W  = STAT_W - FLAG_W;

    logic          start_cond;
    logic          stop_cond;
    logic          line_low;
    acc_stat_t     stat;
    logic [IRQ_SRCS-1:0] irq_src;

    tgt_line_monitor #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .start_cond (start_cond),
        .stop_cond  (stop_cond),
        .line_low   (line_low)
    );

    tgt_status_flags #(.NSRC(IRQ_SRCS)) u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_cond     (start_cond),
        .stop_cond      (stop_cond),
        .line_low       (line_low),
        .addr_hit       (addr_hit),
        .addr_rw        (addr_rw),
        .rx_byte_loaded (rx_byte_loaded),
        .tx_byte_sent   (tx_byte_sent),
        .rxdata_rd      (rxdata_rd),
        .txdata_wr      (txdata_wr),
        .stopflag_wr    (stopflag_wr),
        .stopflag_wdata (stopflag_wdata),
        .irq_en_wr      (irq_en_wr),
        .irq_en_wdata   (irq_en_wdata),
        .stat           (stat),
        .stop_flag      (stop_flag),
        .irq_en         (irq_en)
    );

    // Route flags to their interrupt source slots.
    always_comb begin
        irq_src           = '0;
        irq_src[SRC_RX]   = stat.rx_ready;
        irq_src[SRC_TX]   = stat.tx_empty;
        irq_src[SRC_STOP] = stop_flag;
    end

    tgt_irq_merge #(.NSRC(IRQ_SRCS)) u_irq (
        .src (irq_src),
        .en  (irq_en),
        .irq (irq)
    );

    assign status_word = {{PAD_W{1'b0}}, stat};

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == '0) |-> !irq);

    // R11
    irq_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en[SRC_RX] && status_word[4]) |-> irq);
endmodule

// File: tb/i2c_target_status_bench.sv
module i2c_target_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_in = 1'b1, sda_in = 1'b1;
    logic        addr_hit = 0, addr_rw = 0, rx_byte_loaded = 0, tx_byte_sent = 0;
    logic        rxdata_rd = 0, txdata_wr = 0, stopflag_wr = 0, stopflag_wdata = 0;
    logic        irq_en_wr = 0;
    logic [2:0]  irq_en_wdata = 3'b0;
    logic [15:0] status_word;
    logic        stop_flag;
    logic [2:0]  irq_en;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    bit m_rx, m_tx, m_busy, m_sel, m_dir, m_stop;
    bit [2:0] m_en;
    bit d1_scl = 1, d2_scl = 1, d3_scl = 1;
    bit d1_sda = 1, d2_sda = 1, d3_sda = 1;

    always #2 clk = ~clk;

    i2c_target_status u_i2c_target_status (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .addr_hit(addr_hit), .addr_rw(addr_rw),
        .rx_byte_loaded(rx_byte_loaded), .tx_byte_sent(tx_byte_sent),
        .rxdata_rd(rxdata_rd), .txdata_wr(txdata_wr),
        .stopflag_wr(stopflag_wr), .stopflag_wdata(stopflag_wdata),
        .irq_en_wr(irq_en_wr), .irq_en_wdata(irq_en_wdata),
        .status_word(status_word), .stop_flag(stop_flag),
        .irq_en(irq_en), .irq(irq)
    );

    function automatic bit exp_irq();
        return (m_rx & m_en[0]) | (m_tx & m_en[1]) | (m_stop & m_en[2]);
    endfunction

    function automatic bit [15:0] exp_word();
        return {11'b0, m_rx, m_tx, m_busy, m_sel, m_dir};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: update model at the edge, compare at the falling edge
    task automatic tick();
        bit st, sp, lo;
        @(posedge clk);
        st = d2_scl & d3_scl & d3_sda & ~d2_sda;
        sp = d2_scl & d3_scl & ~d3_sda & d2_sda;
        lo = ~d2_scl | ~d2_sda;
        if (rx_byte_loaded) m_rx = 1; else if (rxdata_rd) m_rx = 0;
        if (tx_byte_sent) m_tx = 1; else if (txdata_wr) m_tx = 0;
        if (st | lo) m_busy = 1; else if (sp) m_busy = 0;
        if ((st | sp) & m_sel) m_stop = 1;
        else if (stopflag_wr & stopflag_wdata) m_stop = 0;
        if (addr_hit) begin m_sel = 1; m_dir = addr_rw; end
        else if (st | sp) begin m_sel = 0; m_dir = 0; end
        if (irq_en_wr) m_en = irq_en_wdata;
        d3_scl = d2_scl; d2_scl = d1_scl; d1_scl = scl_in;
        d3_sda = d2_sda; d2_sda = d1_sda; d1_sda = sda_in;
        @(negedge clk);
        chk("R1 reserved bits", {5'b0, status_word[15:5]}, 16'h0);
        chk("R3 rx_ready", status_word[4], m_rx);
        chk("R4 tx_empty", status_word[3], m_tx);
        chk("R5 busy", status_word[2], m_busy);
        chk("R6 selected", status_word[1], m_sel);
        chk("R7 direction", status_word[0], m_dir);
        chk("R8 stop_flag", stop_flag, m_stop);
        chk("R11 irq_en", irq_en, m_en);
        chk("R11 irq", irq, exp_irq());
        addr_hit = 0; rx_byte_loaded = 0; tx_byte_sent = 0; rxdata_rd = 0;
        txdata_wr = 0; stopflag_wr = 0; irq_en_wr = 0;
    endtask

    task automatic tick3();
        repeat (3) tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 60000) begin
            @(posedge clk);
            cyc++;
        end
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 60000);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R2: reset state, transmit-empty included
        chk("R2 status after reset", status_word, 16'h0);
        chk("R2 stop_flag after reset", stop_flag, 0);
        chk("R2 irq after reset", irq, 0);
        chk("R2 tx_empty after reset", status_word[3], 0);

        irq_en_wr = 1; irq_en_wdata = 3'b111; tick();

        sda_in = 0; tick3();            // start while not selected
        chk("R5 busy on start", status_word[2], 1);
        chk("R8 no stop flag unselected", stop_flag, 0);
        scl_in = 0; tick3();
        addr_hit = 1; addr_rw = 1; tick();
        chk("R6 selected on address", status_word[1], 1);
        chk("R7 direction captured", status_word[0], 1);
        sda_in = 1; tick3();            // data change under low SCL
        scl_in = 1; tick3();
        chk("R12 no condition when SDA moves with SCL low", status_word[1], 1);
        sda_in = 0; tick3();            // repeated start
        chk("R6 cleared by repeated start", status_word[1], 0);
        chk("R7 direction back to 0", status_word[0], 0);
        chk("R8 stop flag on repeated start", stop_flag, 1);
        chk("R11 irq from stop flag", irq, 1);
        stopflag_wr = 1; stopflag_wdata = 0; tick();
        chk("R9 write 0 keeps stop flag", stop_flag, 1);
        stopflag_wr = 1; stopflag_wdata = 1; tick();
        chk("R9 write 1 clears stop flag", stop_flag, 0);
        chk("R11 irq drops after clear", irq, 0);
        rx_byte_loaded = 1; rxdata_rd = 1; tick();
        chk("R10 set beats clear on rx_ready", status_word[4], 1);
        rxdata_rd = 1; tick();
        chk("R3 rx_ready cleared by read", status_word[4], 0);
        tx_byte_sent = 1; tick();
        chk("R4 tx_empty set", status_word[3], 1);
        txdata_wr = 1; tick();
        chk("R4 tx_empty cleared by write", status_word[3], 0);
        sda_in = 1; tick3();            // stop
        chk("R5 busy cleared by stop", status_word[2], 0);
        chk("R8 stop unselected leaves flag", stop_flag, 0);

        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 7);
            if (r == 0) scl_in = ~scl_in;
            else if (r == 1) sda_in = ~sda_in;
            addr_hit       = ($urandom_range(0, 15) == 0);
            addr_rw        = $urandom_range(0, 1);
            rx_byte_loaded = ($urandom_range(0, 7) == 0);
            rxdata_rd      = ($urandom_range(0, 7) == 0);
            tx_byte_sent   = ($urandom_range(0, 7) == 0);
            txdata_wr      = ($urandom_range(0, 7) == 0);
            stopflag_wr    = ($urandom_range(0, 5) == 0);
            stopflag_wdata = $urandom_range(0, 1);
            irq_en_wr      = ($urandom_range(0, 31) == 0);
            irq_en_wdata   = 3'($urandom_range(0, 7));
            tick();
        end
        finish_run();
    end
endmodule